// File: doc/BRIEF.md
# External Static Memory Access Sequencer

This block turns single host requests into timed read and write cycles on an asynchronous external memory bus. The bus has six active-low chip selects, active-low byte lanes, an active-low read strobe, an active-low write strobe, an address bus and a 32-bit data bus. The data bus is split into a driven value, an output enable and an input. Every chip select has its own setup, strobe pulse and total cycle counts, kept separately for reads and for writes. All counts are in clock periods and are measured from the first cycle in which the access drives a new address.

The host offers one request at a time on a valid/ready handshake. A completed read returns its data with a one-cycle valid pulse. A request with illegal timing is consumed without any bus activity and is answered with a one-cycle error pulse. The sequencer inserts idle cycles by itself where two accesses could fight over the bus. It also lengthens zero-hold writes so that address and select still cover the rising edge of the write strobe.

Top module: `exb_seq`

## Requirements
- R1: An access occupies `total` consecutive cycles. In each of them the chip select of the request is low, all other chip selects are high, the byte lanes equal the inverse of `req_be_i`, and the address equals `req_addr_i`. The direction's strobe is low in cycles setup to setup+pulse-1 counted from 0, and the other strobe stays high. `total` is the programmed cycle count, except in the case of R6. `req_cs_i` is a binary index. `mem_cs_no[i]` belongs to index i. The timing field of index i sits at bits `[i*CNT_W +: CNT_W]` of each timing vector.
- R2: A read captures `mem_dq_i` on the clock edge where the read strobe rises. `rsp_valid_o` is high for exactly the following cycle, with the captured word on `rsp_rdata_o`.
- R3: When an access uses a different chip select than the previous successful access, exactly one idle cycle comes between them. In that cycle every chip select, byte lane and strobe is high. If a read-to-write change happens at the same time, the gap is still one cycle.
- R4: A write that follows a read on the same chip select is preceded by exactly one idle cycle with all control lines high.
- R5: On the same chip select, read after read, write after write and read after write run back to back, with no idle cycle in between.
- R6: A write whose cycle count equals setup+pulse gets one extra hold cycle. Chip select, byte lanes and address stay valid for one period after the write strobe rises.
- R7: A request is rejected when its pulse is 0, its cycle count is below setup+pulse, or its chip select index is 6 or 7. It is accepted with no bus cycle. `rsp_err_o` is high for the next cycle only, and the next request is not delayed by any turnaround.
- R8: `mem_dq_oe_o` is high exactly during the cycles of a write access, with `mem_dq_o` equal to the write data. It is low at all other times.
- R9: `req_ready_o` is high while the sequencer is idle and in the last cycle of an access. It is low in idle-gap cycles and in every other cycle of an access.
- R10: During and after reset with no request, all chip selects, byte lanes and strobes are high, `mem_dq_oe_o` is low, `req_ready_o` is high, and `rsp_valid_o` and `rsp_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_setup_i | input | NUM_CS*CNT_W | Read setup count for each chip select |
| rd_pulse_i | input | NUM_CS*CNT_W | Read strobe width for each chip select |
| rd_cycle_i | input | NUM_CS*CNT_W | Read total cycle count for each chip select |
| wr_setup_i | input | NUM_CS*CNT_W | Write setup count for each chip select |
| wr_pulse_i | input | NUM_CS*CNT_W | Write strobe width for each chip select |
| wr_cycle_i | input | NUM_CS*CNT_W | Write total cycle count for each chip select |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request taken this cycle when valid |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_cs_i | input | CS_W | Chip select index |
| req_addr_i | input | ADDR_W | Access address |
| req_be_i | input | DATA_W/8 | Byte lanes, active high |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | DATA_W | Read data |
| rsp_err_o | output | 1 | Rejected request pulse |
| mem_addr_o | output | ADDR_W | External address |
| mem_cs_no | output | NUM_CS | Chip selects, active low |
| mem_be_no | output | DATA_W/8 | Byte lanes, active low |
| mem_rd_no | output | 1 | Read strobe, active low |
| mem_wr_no | output | 1 | Write strobe, active low |
| mem_dq_o | output | DATA_W | Data driven to memory |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | DATA_W | Data returned from memory |

## Verification
A single request stream walks through every pairing of chip-select change and direction change: same select read-read, write-write, write-read and read-write, plus select changes with and without a read-to-write turn. The pairings tell the zero-gap cases apart from the one-gap cases, and they show that a select change combined with a turn still costs only one idle cycle. Each select carries different setup, pulse and cycle values, and zero setup and zero hold are included. This separates strobe placement and width errors from plain cycle-length errors. Rejected requests are placed between valid ones, and reads after writes through a behavioural memory confirm the data path and the write hold.

// File: rtl/exb_pkg.sv
package exb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_ACC  = 2'd2
  } exb_state_e;
endpackage

// File: rtl/exb_cfg_sel.sv
module exb_cfg_sel #(
  parameter int NUM_CS = 6,
  parameter int CNT_W  = 4,
  parameter int CS_W   = 3
) (
  input  logic [CS_W-1:0]         sel_i,
  input  logic                    we_i,
  input  logic [NUM_CS*CNT_W-1:0] rd_setup_i,
  input  logic [NUM_CS*CNT_W-1:0] rd_pulse_i,
  input  logic [NUM_CS*CNT_W-1:0] rd_cycle_i,
  input  logic [NUM_CS*CNT_W-1:0] wr_setup_i,
  input  logic [NUM_CS*CNT_W-1:0] wr_pulse_i,
  input  logic [NUM_CS*CNT_W-1:0] wr_cycle_i,
  output logic [CNT_W-1:0]        setup_o,
  output logic [CNT_W-1:0]        pulse_o,
  output logic [CNT_W:0]          total_o,
  output logic                    bad_o
);
  logic [CNT_W-1:0] rs [NUM_CS];
  logic [CNT_W-1:0] rp [NUM_CS];
  logic [CNT_W-1:0] rc [NUM_CS];
  logic [CNT_W-1:0] ws [NUM_CS];
  logic [CNT_W-1:0] wp [NUM_CS];
  logic [CNT_W-1:0] wc [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_unpack
    assign rs[i] = rd_setup_i[i*CNT_W +: CNT_W];
    assign rp[i] = rd_pulse_i[i*CNT_W +: CNT_W];
    assign rc[i] = rd_cycle_i[i*CNT_W +: CNT_W];
    assign ws[i] = wr_setup_i[i*CNT_W +: CNT_W];
    assign wp[i] = wr_pulse_i[i*CNT_W +: CNT_W];
    assign wc[i] = wr_cycle_i[i*CNT_W +: CNT_W];
  end

  logic            sel_ok;
  logic [CS_W-1:0] idx;
  logic [CNT_W-1:0] cyc;
  logic [CNT_W:0]   sp;

  always_comb begin
    sel_ok  = int'(sel_i) < NUM_CS;
    idx     = sel_ok ? sel_i : '0;
    setup_o = we_i ? ws[idx] : rs[idx];
    pulse_o = we_i ? wp[idx] : rp[idx];
    cyc     = we_i ? wc[idx] : rc[idx];
    sp      = {1'b0, setup_o} + {1'b0, pulse_o};
    bad_o   = !sel_ok || (pulse_o == '0) || ({1'b0, cyc} < sp);
    // zero write hold is stretched by one period
    total_o = (we_i && ({1'b0, cyc} == sp)) ? sp + 1'b1 : {1'b0, cyc};
  end
endmodule

// File: rtl/exb_strobe_gen.sv
module exb_strobe_gen
  import exb_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int CNT_W  = 4,
  parameter int CS_W   = 3,
  parameter int BE_W   = 4
) (
  input  exb_state_e        state_i,
  input  logic [CNT_W:0]    cnt_i,
  input  logic [CNT_W-1:0]  setup_i,
  input  logic [CNT_W-1:0]  pulse_i,
  input  logic              we_i,
  input  logic [CS_W-1:0]   cs_i,
  input  logic [BE_W-1:0]   be_i,
  output logic [NUM_CS-1:0] cs_no,
  output logic [BE_W-1:0]   be_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic              oe_o
);
  logic           act;
  logic           win;
  logic [CNT_W:0] s_ext;
  logic [CNT_W:0] e_ext;

  assign act   = (state_i == ST_ACC);
  assign s_ext = {1'b0, setup_i};
  assign e_ext = s_ext + {1'b0, pulse_i};
  assign win   = (cnt_i >= s_ext) && (cnt_i < e_ext);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_no[i] = !(act && (cs_i == CS_W'(i)));
  end

  assign be_no = act ? ~be_i : '1;
  assign rd_no = !(act && !we_i && win);
  assign wr_no = !(act && we_i && win);
  assign oe_o  = act && we_i;
endmodule

// File: rtl/exb_seq.sv
module exb_seq
  import exb_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CS*CNT_W-1:0] rd_setup_i,
  input  logic [NUM_CS*CNT_W-1:0] rd_pulse_i,
  input  logic [NUM_CS*CNT_W-1:0] rd_cycle_i,
  input  logic [NUM_CS*CNT_W-1:0] wr_setup_i,
  input  logic [NUM_CS*CNT_W-1:0] wr_pulse_i,
  input  logic [NUM_CS*CNT_W-1:0] wr_cycle_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_we_i,
  input  logic [CS_W-1:0]         req_cs_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [BE_W-1:0]         req_be_i,
  input  logic [DATA_W-1:0]       req_wdata_i,
  output logic                    rsp_valid_o,
  output logic [DATA_W-1:0]       rsp_rdata_o,
  output logic                    rsp_err_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [NUM_CS-1:0]       mem_cs_no,
  output logic [BE_W-1:0]         mem_be_no,
  output logic                    mem_rd_no,
  output logic                    mem_wr_no,
  output logic [DATA_W-1:0]       mem_dq_o,
  output logic                    mem_dq_oe_o,
  input  logic [DATA_W-1:0]       mem_dq_i
);
  localparam logic [CNT_W:0] CNT_ONE = 1;

  exb_state_e        state_q;
  logic [CNT_W:0]    cnt_q;
  logic [CNT_W-1:0]  setup_q, pulse_q;
  logic [CNT_W:0]    total_q;
  logic              we_q, have_q;
  logic [CS_W-1:0]   cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q, err_q;

  logic [CNT_W-1:0]  sel_setup, sel_pulse;
  logic [CNT_W:0]    sel_total;
  logic              sel_bad;

  exb_cfg_sel #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .CS_W(CS_W)) u_cfg (
    .sel_i      (req_cs_i),
    .we_i       (req_we_i),
    .rd_setup_i (rd_setup_i),
    .rd_pulse_i (rd_pulse_i),
    .rd_cycle_i (rd_cycle_i),
    .wr_setup_i (wr_setup_i),
    .wr_pulse_i (wr_pulse_i),
    .wr_cycle_i (wr_cycle_i),
    .setup_o    (sel_setup),
    .pulse_o    (sel_pulse),
    .total_o    (sel_total),
    .bad_o      (sel_bad)
  );

  logic last_cyc, accept, need_gap, sample;

  assign last_cyc    = (state_q == ST_ACC) && (cnt_q == total_q - CNT_ONE);
  assign req_ready_o = (state_q == ST_IDLE) || last_cyc;
  assign accept      = req_valid_i && req_ready_o;
  assign need_gap    = have_q && ((req_cs_i != cs_q) || (!we_q && req_we_i));
  assign sample      = (state_q == ST_ACC) && !we_q &&
                       (cnt_q == ({1'b0, setup_q} + {1'b0, pulse_q} - CNT_ONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      setup_q  <= '0;
      pulse_q  <= '0;
      total_q  <= '0;
      we_q     <= 1'b0;
      have_q   <= 1'b0;
      cs_q     <= '0;
      addr_q   <= '0;
      be_q     <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rvalid_q <= sample;
      if (sample) rdata_q <= mem_dq_i;
      err_q <= accept && sel_bad;
      unique case (state_q)
        ST_GAP: begin
          state_q <= ST_ACC;
          cnt_q   <= '0;
        end
        default: begin
          if (state_q == ST_ACC && !last_cyc) begin
            cnt_q <= cnt_q + CNT_ONE;
          end else if (accept && !sel_bad) begin
            state_q <= need_gap ? ST_GAP : ST_ACC;
            cnt_q   <= '0;
            setup_q <= sel_setup;
            pulse_q <= sel_pulse;
            total_q <= sel_total;
            we_q    <= req_we_i;
            cs_q    <= req_cs_i;
            addr_q  <= req_addr_i;
            be_q    <= req_be_i;
            wdata_q <= req_wdata_i;
            have_q  <= 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  exb_strobe_gen #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .CS_W(CS_W), .BE_W(BE_W)) u_strb (
    .state_i (state_q),
    .cnt_i   (cnt_q),
    .setup_i (setup_q),
    .pulse_i (pulse_q),
    .we_i    (we_q),
    .cs_i    (cs_q),
    .be_i    (be_q),
    .cs_no   (mem_cs_no),
    .be_no   (mem_be_no),
    .rd_no   (mem_rd_no),
    .wr_no   (mem_wr_no),
    .oe_o    (mem_dq_oe_o)
  );

  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign rsp_valid_o = rvalid_q;
  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o   = err_q;
endmodule

// File: rtl/exb_seq_chk.sv
module exb_seq_chk #(
  parameter int NUM_CS = 6,
  parameter int ADDR_W = 24,
  parameter int BE_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CS-1:0] mem_cs_no,
  input logic [BE_W-1:0]   mem_be_no,
  input logic              mem_rd_no,
  input logic              mem_wr_no,
  input logic              mem_dq_oe_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              rsp_valid_o,
  input logic              rsp_err_o
);
  p_cs_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));

  p_strobe_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_rd_no && !mem_wr_no));

  p_idle_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mem_cs_no) |-> (mem_rd_no && mem_wr_no && (&mem_be_no) && !mem_dq_oe_o));

  p_cs_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&mem_cs_no) && !(&$past(mem_cs_no))) |-> (mem_cs_no == $past(mem_cs_no)));

  p_turn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (&$past(mem_cs_no)));

  p_wr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_wr_no) |-> (!(&mem_cs_no) && mem_cs_no == $past(mem_cs_no) &&
                          mem_addr_o == $past(mem_addr_o)));

  p_err_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> ((&mem_cs_no) && !rsp_valid_o));

  p_oe_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!(&mem_cs_no) && mem_rd_no));
endmodule

bind exb_seq exb_seq_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_cs_no   (mem_cs_no),
  .mem_be_no   (mem_be_no),
  .mem_rd_no   (mem_rd_no),
  .mem_wr_no   (mem_wr_no),
  .mem_dq_oe_o (mem_dq_oe_o),
  .mem_addr_o  (mem_addr_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o)
);

// File: tb/tb_exb_seq.sv
`timescale 1ns/100ps
module tb_exb_seq;
  localparam int NCS = 6;
  localparam int CW  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [NCS*CW-1:0] rs_v, rp_v, rc_v, ws_v, wp_v, wc_v;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [2:0]  req_cs = '0;
  logic [23:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err, rd_n, wr_n, dq_oe;
  logic [31:0] rsp_rdata, dq_o, dq_i;
  logic [23:0] m_addr;
  logic [5:0]  cs_n;
  logic [3:0]  be_n;

  exb_seq dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_setup_i(rs_v), .rd_pulse_i(rp_v), .rd_cycle_i(rc_v),
    .wr_setup_i(ws_v), .wr_pulse_i(wp_v), .wr_cycle_i(wc_v),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_cs_i(req_cs), .req_addr_i(req_addr), .req_be_i(req_be), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .mem_addr_o(m_addr), .mem_cs_no(cs_n), .mem_be_no(be_n), .mem_rd_no(rd_n),
    .mem_wr_no(wr_n), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // timing per chip select: setup, pulse, cycle
  int t_rs[NCS] = '{1, 0, 2, 1, 3, 1};
  int t_rp[NCS] = '{2, 1, 3, 0, 1, 1};
  int t_rc[NCS] = '{4, 1, 6, 3, 3, 2};
  int t_ws[NCS] = '{1, 0, 2, 1, 0, 1};
  int t_wp[NCS] = '{2, 1, 1, 1, 2, 1};
  int t_wc[NCS] = '{3, 2, 5, 3, 2, 2};

  // behavioural memory
  logic [31:0] mem [16];
  logic wr_prev = 1'b1;
  assign dq_i = (!rd_n) ? mem[m_addr[3:0]] : 32'h0BAD_0BAD;
  always @(negedge clk) begin
    if (!wr_prev && wr_n)
      for (int b = 0; b < 4; b++)
        if (!be_n[b]) mem[m_addr[3:0]][b*8 +: 8] = dq_o[b*8 +: 8];
    wr_prev = wr_n;
  end

  typedef struct {
    logic [5:0] cs_n; logic [3:0] be_n; logic rd_n, wr_n, oe, rdy, err, rv;
    logic [23:0] addr; logic [31:0] dq, rdata; string tg;
  } exp_t;
  exp_t tr[$];

  int q_we[$], q_cs[$], q_addr[$], q_be[$];
  logic [31:0] q_wd[$];
  int n_chk = 0, n_err = 0;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic add(int we, int cs, int a, int be, logic [31:0] wd);
    q_we.push_back(we); q_cs.push_back(cs); q_addr.push_back(a);
    q_be.push_back(be); q_wd.push_back(wd);
  endtask

  function automatic exp_t idle_e(logic rdy, string tg);
    exp_t e;
    e.cs_n = '1; e.be_n = '1; e.rd_n = 1; e.wr_n = 1; e.oe = 0; e.rdy = rdy;
    e.err = 0; e.rv = 0; e.addr = '0; e.dq = '0; e.rdata = '0; e.tg = tg;
    return e;
  endfunction

  task automatic build();
    logic [31:0] shadow [16];
    logic [31:0] rv_dat [int];
    int last_cs = -1;
    bit last_rd = 0;
    exp_t e;
    for (int i = 0; i < 16; i++) shadow[i] = 32'hC0DE_0000 | i;
    tr.push_back(idle_e(1, "R9"));
    for (int i = 0; i < q_we.size(); i++) begin
      int cs = q_cs[i];
      bit we = q_we[i] != 0;
      int s, p, c, tot, start;
      bit gap;
      if (cs >= NCS) begin
        s = 0; p = 0; c = 0;
      end else begin
        s = we ? t_ws[cs] : t_rs[cs];
        p = we ? t_wp[cs] : t_rp[cs];
        c = we ? t_wc[cs] : t_rc[cs];
      end
      if (cs >= NCS || p == 0 || c < s + p) begin
        e = idle_e(1, "R7"); e.err = 1; tr.push_back(e);
        continue;
      end
      gap = (last_cs >= 0) && (cs != last_cs || (last_rd && we));
      if (gap) tr.push_back(idle_e(0, (cs == last_cs) ? "R4" : "R3"));
      tot = (we && c == s + p) ? c + 1 : c;
      start = tr.size();
      for (int k = 0; k < tot; k++) begin
        e = idle_e(k == tot - 1, "R1");
        if (k == 0 && !gap && last_cs >= 0 && tr[start-1].cs_n != '1) e.tg = "R5";
        if (we && c == s + p && k == tot - 1) e.tg = "R6";
        e.cs_n = ~(6'(1) << cs);
        e.be_n = ~4'(q_be[i]);
        e.addr = 24'(q_addr[i]);
        e.rd_n = !(!we && k >= s && k < s + p);
        e.wr_n = !(we && k >= s && k < s + p);
        e.oe = we;
        e.dq = q_wd[i];
        tr.push_back(e);
      end
      if (!we) rv_dat[start + s + p] = shadow[q_addr[i] & 15];
      else
        for (int b = 0; b < 4; b++)
          if (q_be[i][b]) shadow[q_addr[i] & 15][b*8 +: 8] = q_wd[i][b*8 +: 8];
      last_cs = cs; last_rd = !we;
    end
    for (int k = 0; k < 4; k++) tr.push_back(idle_e(1, "R9"));
    foreach (rv_dat[idx]) begin
      tr[idx].rv = 1;
      tr[idx].rdata = rv_dat[idx];
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int ri;
    for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE_0000 | i;
    for (int i = 0; i < NCS; i++) begin
      rs_v[i*CW +: CW] = CW'(t_rs[i]); rp_v[i*CW +: CW] = CW'(t_rp[i]);
      rc_v[i*CW +: CW] = CW'(t_rc[i]); ws_v[i*CW +: CW] = CW'(t_ws[i]);
      wp_v[i*CW +: CW] = CW'(t_wp[i]); wc_v[i*CW +: CW] = CW'(t_wc[i]);
    end
    // R10: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs_n == '1 && be_n == '1 && rd_n && wr_n && !dq_oe, "R10", "controls in reset",
        {rd_n, wr_n, dq_oe, be_n, cs_n}, {1'b1, 1'b1, 1'b0, 4'hF, 6'h3F});
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_valid && !rsp_err, "R10", "ready/valid/err after reset",
        {req_ready, rsp_valid, rsp_err}, 3'b100);

    add(1, 0, 2, 4'hF, 32'hA1A1_0002);
    add(1, 0, 3, 4'h3, 32'hB2B2_0303);
    add(0, 0, 2, 4'hF, 0);
    add(0, 0, 3, 4'hF, 0);
    add(1, 0, 4, 4'hF, 32'hC3C3_0404);
    add(0, 1, 4, 4'hF, 0);
    add(0, 1, 2, 4'h1, 0);
    add(1, 2, 5, 4'hF, 32'hD4D4_0505);
    add(0, 3, 1, 4'hF, 0);
    add(1, 3, 6, 4'hC, 32'hE5E5_0606);
    add(0, 4, 1, 4'hF, 0);
    add(1, 4, 7, 4'hF, 32'hF6F6_0707);
    add(1, 5, 6, 4'h8, 32'h1700_0000);
    add(0, 5, 6, 4'hF, 0);
    add(0, 2, 7, 4'hF, 0);
    add(0, 6, 1, 4'hF, 0);
    add(0, 5, 5, 4'hF, 0);
    add(1, 5, 7, 4'h2, 32'h0000_9900);
    add(0, 1, 7, 4'hF, 0);
    build();

    ri = 0;
    for (int t = 0; t < tr.size(); t++) begin
      exp_t e;
      @(posedge clk); #1;
      req_valid = ri < q_we.size();
      if (ri < q_we.size()) begin
        req_we = q_we[ri] != 0; req_cs = 3'(q_cs[ri]); req_addr = 24'(q_addr[ri]);
        req_be = 4'(q_be[ri]); req_wdata = q_wd[ri];
      end
      @(negedge clk);
      e = tr[t];
      chk(cs_n == e.cs_n && be_n == e.be_n && rd_n == e.rd_n && wr_n == e.wr_n, e.tg,
          $sformatf("controls cycle %0d", t),
          {18'd0, rd_n, wr_n, be_n, cs_n}, {18'd0, e.rd_n, e.wr_n, e.be_n, e.cs_n});
      if (e.cs_n != '1) chk(m_addr == e.addr, e.tg, "address", m_addr, e.addr);
      chk(req_ready == e.rdy, "R9", $sformatf("ready cycle %0d", t), req_ready, e.rdy);
      chk(rsp_err == e.err, "R7", $sformatf("error cycle %0d", t), rsp_err, e.err);
      chk(rsp_valid == e.rv, "R2", $sformatf("read valid cycle %0d", t), rsp_valid, e.rv);
      if (e.rv) chk(rsp_rdata == e.rdata, "R2", "read data", rsp_rdata, e.rdata);
      chk(dq_oe == e.oe, "R8", $sformatf("drive enable cycle %0d", t), dq_oe, e.oe);
      if (e.oe) chk(dq_o == e.dq, "R8", "write data", dq_o, e.dq);
      if (req_valid && req_ready) ri++;
    end
    chk(ri == q_we.size(), "R9", "all requests taken", ri, q_we.size());
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule